// File: doc/BRIEF.md
# Glitch-Safe Sampled Host Register Decoder

This block is the register front end of a peripheral that is attached to a fast processor over a non-multiplexed bus with separate active-low read and write strobes. On such processors the address and chip select can move on the same edge that ends the read strobe. A plain combinational decode of address, select and strobe would then produce short false decode pulses. Any register with a read side effect could be corrupted by such a pulse: a status register that clears when read, a data window whose pointer steps on each read, or an identifier register whose read is acknowledged to the network side.

The block passes each host strobe through a clocked delay line. The 3-bit address and the chip select are captured into flip-flops when the strobe, delayed by `SAMPLE_DLY` clocks, falls. All decoding then uses the captured copy. The read is acted on when the strobe, delayed further by `READ_DLY` clocks, falls. At that point the read data is frozen and the output enable is raised. Each side effect is committed exactly once, when that further-delayed strobe rises. Writes use the same capture scheme. The registers behind the decoder are:

- a diagnostic status register, which clears on read;
- an identifier register, whose read raises an acknowledge pulse;
- a split pointer into a local byte memory of 2^`RAM_AW` entries;
- a data window into that memory, which advances the pointer on every access.

Top module: `glitchsafe_host_dec`

## Requirements
- R1: After reset, `host_rdata_oe`, `host_rdata` and `next_id_taken` are 0. The status register and the memory pointer are 0.
- R2: The address and chip select are taken once per read, at the delayed sampling point. Changes to `host_addr` or `host_cs_n` after that point, including changes on the cycle the read strobe is released, alter neither the returned data nor the register that receives the side effect.
- R3: A read whose chip select is sampled high never raises `host_rdata_oe` and causes no side effect.
- R4: Address 0 returns the status value as it stood when the read began. When the read ends, only the returned bits are cleared. Bits raised through `diag_set` during the read, including on the clearing cycle, are kept.
- R5: Address 4 returns the memory byte at the pointer, and each read advances the pointer by exactly one. A read strobe only one clock long still counts as one read. The pointer carries from the low byte into the high part and wraps from 2^`RAM_AW`-1 to 0.
- R6: Address 1 returns `next_id`, and each such read pulses `next_id_taken` high for exactly one clock.
- R7: Address 3 reads and writes pointer bits 7:0. Address 2 reads and writes pointer bits `RAM_AW`-1:8, placed at data bit 0 upwards; all other bits read as 0.
- R8: A write to address 4 stores the data byte at the pointer and advances the pointer by one, with the same carry and wrap as reads.
- R9: Address or chip-select activity while both strobes stay high causes no side effect.
- R10: Writes to addresses 0 and 1 have no effect. Addresses 5, 6 and 7 read as 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that runs the strobe delay lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_addr | input | 3 | Host register address |
| host_cs_n | input | 1 | Host chip select, active low |
| host_rd_n | input | 1 | Host read strobe, active low |
| host_wr_n | input | 1 | Host write strobe, active low |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Read data, frozen for the duration of a read |
| host_rdata_oe | output | 1 | Drive enable for the host data bus; the bus is released while low |
| diag_set | input | 8 | Per-bit status set requests from the core |
| next_id | input | 8 | Identifier value offered to the host |
| next_id_taken | output | 1 | One-clock pulse for each completed identifier read |

## Verification
The bench builds the block with its defaults: `RAM_AW` = 10, `SAMPLE_DLY` = 2 and `READ_DLY` = 3. With a 10-bit pointer, the high part holds only two bits. The carry from 0x1FF to 0x200 and the wrap from 0x3FF to 0 can therefore both be reached with a handful of writes, and the masking of unused high bits on readback is observable. The one-clock gap between the sampling point and the internal read lets the bench move the address and chip select inside a read, after capture but before release, and confirm that side effects follow the captured values.

// File: rtl/ghd_pkg.sv
package ghd_pkg;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        REG_DIAG     = 3'd0,
        REG_NEXT_ID  = 3'd1,
        REG_PTR_HI   = 3'd2,
        REG_PTR_LO   = 3'd3,
        REG_RAM_DATA = 3'd4
    } reg_sel_e;
endpackage

// File: rtl/ghd_strobe_delay.sv
// Clocked delay line for one active-low host strobe. Reports the fall of
// the sampling tap and the fall and rise of the later action tap.
module ghd_strobe_delay #(
    parameter int SAMPLE_DLY = 2,
    parameter int ACT_DLY    = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_n,
    output logic samp_fell,
    output logic act_fell,
    output logic act_rose
);
    localparam int LEN = ACT_DLY + 1;

    logic [LEN-1:0] sr_d, sr_q;

    always_comb begin
        sr_d = {sr_q[LEN-2:0], strobe_n};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr_q <= '1;
        else        sr_q <= sr_d;
    end

    assign samp_fell = !sr_q[SAMPLE_DLY-1] &&  sr_q[SAMPLE_DLY];
    assign act_fell  = !sr_q[ACT_DLY-1]    &&  sr_q[ACT_DLY];
    assign act_rose  =  sr_q[ACT_DLY-1]    && !sr_q[ACT_DLY];
endmodule

// File: rtl/ghd_ram.sv
// Local byte memory: synchronous write, combinational read.
module ghd_ram #(
    parameter int AW = 10,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 2 ** AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[addr] <= wdata;
    end

    assign rdata = mem[addr];
endmodule

// File: rtl/glitchsafe_host_dec.sv
// Host register decoder. Address and select are captured on a delayed
// strobe edge; side effects commit once on the rise of a later tap.
module glitchsafe_host_dec
    import ghd_pkg::*;
#(
    parameter int RAM_AW     = 10,   // 9..16
    parameter int SAMPLE_DLY = 2,
    parameter int READ_DLY   = 3     // must exceed SAMPLE_DLY
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic              host_cs_n,
    input  logic              host_rd_n,
    input  logic              host_wr_n,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    output logic              host_rdata_oe,
    input  logic [DATA_W-1:0] diag_set,
    input  logic [DATA_W-1:0] next_id,
    output logic              next_id_taken
);
    localparam int HI_W = RAM_AW - 8;

    typedef struct packed {
        logic [ADDR_W-1:0] raddr;
        logic              rcs;
        logic              rd_act;
        logic [DATA_W-1:0] rdata;
        logic [ADDR_W-1:0] waddr;
        logic              wcs;
        logic              wr_act;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] diag;
        logic [RAM_AW-1:0] ptr;
        logic              nid_ack;
    } state_t;

    state_t s_d, s_q;

    logic              rd_samp, rd_start, rd_end;
    logic              wr_samp, wr_start, wr_end;
    logic              rd_commit, wr_commit, ram_we;
    logic [DATA_W-1:0] ram_q, rd_mux;
    logic [DATA_W-1:0] diag_now;
    logic [RAM_AW-1:0] ptr_now;

    ghd_strobe_delay #(.SAMPLE_DLY(SAMPLE_DLY), .ACT_DLY(READ_DLY)) i_rd_dly (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe_n (host_rd_n),
        .samp_fell(rd_samp),
        .act_fell (rd_start),
        .act_rose (rd_end)
    );

    ghd_strobe_delay #(.SAMPLE_DLY(SAMPLE_DLY), .ACT_DLY(READ_DLY)) i_wr_dly (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe_n (host_wr_n),
        .samp_fell(wr_samp),
        .act_fell (wr_start),
        .act_rose (wr_end)
    );

    ghd_ram #(.AW(RAM_AW), .DW(DATA_W)) i_ram (
        .clk  (clk),
        .we   (ram_we),
        .addr (s_q.ptr),
        .wdata(s_q.wdata),
        .rdata(ram_q)
    );

    assign rd_commit = rd_end && s_q.rd_act;
    assign wr_commit = wr_end && s_q.wr_act;
    assign ram_we    = wr_commit && (s_q.waddr == REG_RAM_DATA);

    // Read selection from the captured address only.
    always_comb begin
        case (s_q.raddr)
            REG_DIAG:     rd_mux = s_q.diag;
            REG_NEXT_ID:  rd_mux = next_id;
            REG_PTR_HI:   rd_mux = DATA_W'(s_q.ptr >> 8);
            REG_PTR_LO:   rd_mux = s_q.ptr[7:0];
            REG_RAM_DATA: rd_mux = ram_q;
            default:      rd_mux = '0;
        endcase
    end

    always_comb begin
        s_d         = s_q;
        s_d.nid_ack = 1'b0;
        s_d.diag    = s_q.diag | diag_set;

        if (!host_wr_n) s_d.wdata = host_wdata;

        if (rd_samp) begin
            s_d.raddr = host_addr;
            s_d.rcs   = !host_cs_n;
        end
        if (wr_samp) begin
            s_d.waddr = host_addr;
            s_d.wcs   = !host_cs_n;
        end

        if (rd_start) begin
            s_d.rd_act = s_q.rcs;
            if (s_q.rcs) s_d.rdata = rd_mux;
        end
        if (rd_end)   s_d.rd_act = 1'b0;
        if (wr_start) s_d.wr_act = s_q.wcs;
        if (wr_end)   s_d.wr_act = 1'b0;

        if (rd_commit) begin
            case (s_q.raddr)
                REG_DIAG:     s_d.diag    = (s_q.diag & ~s_q.rdata) | diag_set;
                REG_NEXT_ID:  s_d.nid_ack = 1'b1;
                REG_RAM_DATA: s_d.ptr     = s_q.ptr + 1'b1;
                default:      ;
            endcase
        end

        if (wr_commit) begin
            case (s_q.waddr)
                REG_PTR_HI:   s_d.ptr[RAM_AW-1:8] = s_q.wdata[HI_W-1:0];
                REG_PTR_LO:   s_d.ptr[7:0]        = s_q.wdata;
                REG_RAM_DATA: s_d.ptr             = s_q.ptr + 1'b1;
                default:      ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign host_rdata    = s_q.rdata;
    assign host_rdata_oe = s_q.rd_act;
    assign next_id_taken = s_q.nid_ack;
    assign diag_now      = s_q.diag;
    assign ptr_now       = s_q.ptr;
endmodule

// File: rtl/glitchsafe_host_dec_chk.sv
module glitchsafe_host_dec_chk #(
    parameter int RAM_AW = 10,
    parameter int OFS    = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_n,
    input logic              rdata_oe,
    input logic [7:0]        rdata,
    input logic              nid_ack,
    input logic [7:0]        diag,
    input logic [RAM_AW-1:0] ptr,
    input logic              wr_commit
);
    // The enable only rises for a read whose select was low at capture.
    assert_oe_needs_cs_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rdata_oe) |-> !$past(cs_n, OFS));

    // Returned data holds still for the whole read.
    assert_rdata_frozen_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rdata_oe && $past(rdata_oe)) |-> $stable(rdata));

    // Acknowledge is a single-clock pulse.
    assert_ack_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        nid_ack |=> !nid_ack);

    // Acknowledge only follows a real read.
    assert_ack_after_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
        nid_ack |-> $past(rdata_oe));

    // Status bits fall only at the end of a real read.
    assert_diag_clear_on_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (|($past(diag) & ~diag)) |-> $past(rdata_oe));

    // The pointer moves by one step, or by a pointer write.
    assert_ptr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr != $past(ptr)) |-> ((ptr == RAM_AW'($past(ptr) + 1'b1)) || $past(wr_commit)));
endmodule

bind glitchsafe_host_dec glitchsafe_host_dec_chk #(
    .RAM_AW(RAM_AW),
    .OFS   (READ_DLY - SAMPLE_DLY + 1)
) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_n     (host_cs_n),
    .rdata_oe (host_rdata_oe),
    .rdata    (host_rdata),
    .nid_ack  (next_id_taken),
    .diag     (diag_now),
    .ptr      (ptr_now),
    .wr_commit(wr_commit)
);

// File: tb/test_glitchsafe_host_dec.sv
`timescale 1ns/1ps
module test_glitchsafe_host_dec;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] host_addr = 3'd0;
    logic       host_cs_n = 1'b1;
    logic       host_rd_n = 1'b1;
    logic       host_wr_n = 1'b1;
    logic [7:0] host_wdata = 8'h00;
    logic [7:0] host_rdata;
    logic       host_rdata_oe;
    logic [7:0] diag_set = 8'h00;
    logic [7:0] next_id = 8'h3C;
    logic       next_id_taken;

    int n_checks = 0;
    int n_errors = 0;
    int ack_cnt  = 0;
    int oe_cnt   = 0;

    always #2.5 clk = ~clk;

    glitchsafe_host_dec i_glitchsafe_host_dec (
        .clk          (clk),
        .rst_n        (rst_n),
        .host_addr    (host_addr),
        .host_cs_n    (host_cs_n),
        .host_rd_n    (host_rd_n),
        .host_wr_n    (host_wr_n),
        .host_wdata   (host_wdata),
        .host_rdata   (host_rdata),
        .host_rdata_oe(host_rdata_oe),
        .diag_set     (diag_set),
        .next_id      (next_id),
        .next_id_taken(next_id_taken)
    );

    always @(negedge clk) begin
        if (next_id_taken) ack_cnt++;
        if (host_rdata_oe) oe_cnt++;
    end

    // Vector: {req code, write, address, data}. Req code: 0=R5 1=R7 2=R8 3=R10.
    localparam int NV = 33;
    localparam logic [14:0] VEC [NV] = '{
        {3'd1, 1'b1, 3'd2, 8'h01}, {3'd1, 1'b1, 3'd3, 8'hFE},
        {3'd1, 1'b0, 3'd2, 8'h01}, {3'd1, 1'b0, 3'd3, 8'hFE},
        {3'd2, 1'b1, 3'd4, 8'hA1}, {3'd2, 1'b1, 3'd4, 8'hB2},
        {3'd2, 1'b1, 3'd4, 8'hC3}, {3'd2, 1'b0, 3'd2, 8'h02},
        {3'd2, 1'b0, 3'd3, 8'h01}, {3'd0, 1'b1, 3'd3, 8'hFE},
        {3'd0, 1'b1, 3'd2, 8'h01}, {3'd0, 1'b0, 3'd4, 8'hA1},
        {3'd0, 1'b0, 3'd4, 8'hB2}, {3'd0, 1'b0, 3'd4, 8'hC3},
        {3'd0, 1'b0, 3'd2, 8'h02}, {3'd0, 1'b0, 3'd3, 8'h01},
        {3'd1, 1'b1, 3'd2, 8'hFF}, {3'd1, 1'b0, 3'd2, 8'h03},
        {3'd2, 1'b1, 3'd3, 8'hFF}, {3'd2, 1'b1, 3'd4, 8'h5A},
        {3'd2, 1'b0, 3'd2, 8'h00}, {3'd2, 1'b0, 3'd3, 8'h00},
        {3'd0, 1'b1, 3'd2, 8'h03}, {3'd0, 1'b1, 3'd3, 8'hFF},
        {3'd0, 1'b0, 3'd4, 8'h5A}, {3'd0, 1'b0, 3'd3, 8'h00},
        {3'd3, 1'b0, 3'd5, 8'h00}, {3'd3, 1'b0, 3'd6, 8'h00},
        {3'd3, 1'b0, 3'd7, 8'h00}, {3'd3, 1'b1, 3'd1, 8'h77},
        {3'd3, 1'b0, 3'd1, 8'h3C}, {3'd3, 1'b1, 3'd0, 8'hFF},
        {3'd3, 1'b0, 3'd0, 8'h00}
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    // Read cycle; address moves to ~a at release with select held low.
    task automatic do_read(input logic [2:0] a, input logic cs,
                           output logic [7:0] d, output logic oe);
        @(negedge clk);
        host_addr = a; host_cs_n = !cs; host_rd_n = 1'b0;
        repeat (6) @(negedge clk);
        d = host_rdata; oe = host_rdata_oe;
        host_rd_n = 1'b1; host_addr = ~a; host_cs_n = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    task automatic do_write(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_cs_n = 1'b0; host_wdata = d; host_wr_n = 1'b0;
        repeat (5) @(negedge clk);
        host_wr_n = 1'b1; host_addr = ~a; host_wdata = ~d;
        repeat (6) @(negedge clk);
    endtask

    task automatic pulse_diag(input logic [7:0] v);
        @(negedge clk); diag_set = v;
        @(negedge clk); diag_set = 8'h00;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [7:0] d;
        logic       oe;
        int         base;
        string      tag;

        // R1 reset state
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", {7'd0, host_rdata_oe}, 8'h00);
        chk("R1", host_rdata, 8'h00);
        chk("R1", {7'd0, next_id_taken}, 8'h00);
        do_read(3'd0, 1'b1, d, oe); chk("R1", d, 8'h00);
        do_read(3'd3, 1'b1, d, oe); chk("R1", d, 8'h00);
        do_read(3'd2, 1'b1, d, oe); chk("R1", d, 8'h00);

        // Vector table
        for (int i = 0; i < NV; i++) begin
            case (VEC[i][14:12])
                3'd0:    tag = "R5";
                3'd1:    tag = "R7";
                3'd2:    tag = "R8";
                default: tag = "R10";
            endcase
            if (VEC[i][11]) do_write(VEC[i][10:8], VEC[i][7:0]);
            else begin
                do_read(VEC[i][10:8], 1'b1, d, oe);
                chk(tag, d, VEC[i][7:0]);
            end
        end

        // R4 clear on read
        pulse_diag(8'h05);
        do_read(3'd0, 1'b1, d, oe); chk("R4", d, 8'h05);
        do_read(3'd0, 1'b1, d, oe); chk("R4", d, 8'h00);
        // R4 bits raised during the read and on the clearing cycle survive
        pulse_diag(8'h05);
        @(negedge clk);
        host_addr = 3'd0; host_cs_n = 1'b0; host_rd_n = 1'b0;
        repeat (6) @(negedge clk);
        chk("R4", host_rdata, 8'h05);
        diag_set = 8'h40;
        @(negedge clk);
        diag_set = 8'h80; host_rd_n = 1'b1; host_addr = 3'd7;
        repeat (6) @(negedge clk);
        diag_set = 8'h00;
        do_read(3'd0, 1'b1, d, oe); chk("R4", d, 8'hC0);
        do_read(3'd0, 1'b1, d, oe); chk("R4", d, 8'h00);

        // R6 identifier read and acknowledge
        base = ack_cnt;
        do_read(3'd1, 1'b1, d, oe); chk("R6", d, 8'h3C);
        chk("R6", 8'(ack_cnt - base), 8'd1);
        next_id = 8'hA5;
        base = ack_cnt;
        do_read(3'd1, 1'b1, d, oe); chk("R6", d, 8'hA5);
        chk("R6", 8'(ack_cnt - base), 8'd1);

        // R3 reads with select high
        pulse_diag(8'h10);
        base = oe_cnt;
        do_read(3'd0, 1'b0, d, oe);
        chk("R3", {7'd0, oe}, 8'h00);
        do_read(3'd4, 1'b0, d, oe);
        chk("R3", 8'(oe_cnt - base), 8'd0);
        do_read(3'd0, 1'b1, d, oe); chk("R3", d, 8'h10);
        do_read(3'd3, 1'b1, d, oe); chk("R3", d, 8'h00);

        // R2 address and select move after capture
        pulse_diag(8'h22);
        @(negedge clk);
        host_addr = 3'd0; host_cs_n = 1'b0; host_rd_n = 1'b0;
        repeat (3) @(negedge clk);
        host_addr = 3'd4; host_cs_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R2", host_rdata, 8'h22);
        host_rd_n = 1'b1; host_cs_n = 1'b0;
        repeat (6) @(negedge clk);
        do_read(3'd0, 1'b1, d, oe); chk("R2", d, 8'h00);
        do_read(3'd3, 1'b1, d, oe); chk("R2", d, 8'h00);
        do_write(3'd3, 8'h10);
        pulse_diag(8'h01);
        @(negedge clk);
        host_addr = 3'd4; host_cs_n = 1'b0; host_rd_n = 1'b0;
        repeat (6) @(negedge clk);
        host_rd_n = 1'b1; host_addr = 3'd0;
        repeat (6) @(negedge clk);
        do_read(3'd0, 1'b1, d, oe); chk("R2", d, 8'h01);
        do_read(3'd3, 1'b1, d, oe); chk("R2", d, 8'h11);

        // R9 bus activity with both strobes high
        pulse_diag(8'h08);
        base = ack_cnt;
        for (int k = 0; k < 16; k++) begin
            @(negedge clk);
            host_addr = 3'(k); host_cs_n = k[0];
        end
        repeat (4) @(negedge clk);
        chk("R9", 8'(ack_cnt - base), 8'd0);
        do_read(3'd0, 1'b1, d, oe); chk("R9", d, 8'h08);
        do_read(3'd3, 1'b1, d, oe); chk("R9", d, 8'h11);

        // R5 one-clock read strobe counts once
        @(negedge clk);
        host_addr = 3'd4; host_cs_n = 1'b0; host_rd_n = 1'b0;
        @(negedge clk);
        host_rd_n = 1'b1;
        repeat (8) @(negedge clk);
        do_read(3'd3, 1'b1, d, oe); chk("R5", d, 8'h12);

        finish_run();
    end
endmodule